// File: doc/BRIEF.md
# AUX Channel Ownership Arbiter

This block decides who may drive a shared DisplayPort AUX channel: a host software port or an embedded microcontroller. Each side has a one-cycle claim strobe and a one-cycle release strobe. The block reports the current owner on a two-bit status output.

When software claims a free channel that has never been enabled, the block first runs a bring-up handshake with the channel logic. It raises enable and reset together and waits for reset-done to rise. It then drops reset and waits for reset-done to fall. Only after that is software granted. Each wait is bounded. If a wait expires, the claim is abandoned, the channel is disabled again and a sticky error flag is set. Once the handshake has succeeded, enable stays high, so later software claims are granted directly.

The microcontroller never needs the handshake. When both sides claim a free channel in the same cycle, the microcontroller wins. A software claim that meets a microcontroller-held channel is refused with a one-cycle pulse.

Top module: `aux_own_arb`

## Requirements
- R1: Ownership status encoding is 0 = free, 1 = software owns, 2 = microcontroller owns. The value 3 never appears. After reset the status is 0, enable, reset, the refusal pulse and the error flag are all 0.
- R2: A software claim while the microcontroller owns the channel produces `swRefused` = 1 in the cycle after the claim. The status stays 2, and enable and reset do not change.
- R3: A software claim on a free, disabled channel drives `auxEnable` and `auxReset` high in the cycle after the claim. `auxReset` falls in the cycle after `resetDone` is sampled high. The status reads 0 throughout the handshake.
- R4: Software is granted (status 1) in the cycle after `resetDone` is sampled low following the reset drop. If the channel is already enabled, software is granted in the cycle after the claim, with no reset pulse.
- R5: A release strobe from the current owner returns the status to 0 in the next cycle. A release strobe from a side that does not own the channel has no effect.
- R6: Each reset-done wait lasts at most `POLL_INTERVAL * POLL_LIMIT` cycles. On expiry, `seqError` is set and stays set until reset. Enable and reset are cleared, and the status stays 0.
- R7: Simultaneous claims on a free channel grant the microcontroller (status 2), and software gets `swRefused`.
- R8: A microcontroller claim while software owns the channel, or while the handshake is running, is ignored. A software claim during the handshake or while software already owns the channel is ignored and not refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swReq | input | 1 | Software claim strobe |
| swRelease | input | 1 | Software done-using strobe |
| mcuReq | input | 1 | Microcontroller claim strobe |
| mcuRelease | input | 1 | Microcontroller release strobe |
| resetDone | input | 1 | Reset-done indication from the channel logic |
| auxEnable | output | 1 | Channel enable |
| auxReset | output | 1 | Channel reset request |
| ownStatus | output | 2 | Owner code (0 free, 1 software, 2 microcontroller) |
| swRefused | output | 1 | One-cycle pulse: software claim refused |
| seqError | output | 1 | Sticky flag: a reset-done wait expired |

## Verification
The bench builds the block with `POLL_INTERVAL` = 2 and `POLL_LIMIT` = 11. This gives a 22-cycle wait window, so both expiry paths fit in a short run: reset-done never rising, and reset-done never falling. The bench checks the cycle just before each expiry and the expiry cycle itself, then confirms the error flag survives a later successful handshake.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;

  typedef enum logic [2:0] {
    ST_FREE,
    ST_MCU,
    ST_RST_HI,
    ST_RST_LO,
    ST_SW
  } arbState_t;

  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_SW   = 2'd1;
  localparam logic [1:0] OWN_MCU  = 2'd2;

  typedef struct packed {
    logic startSeq;
    logic dropRst;
    logic abortSeq;
    logic cntRun;
    logic grantSw;
    logic grantMcu;
    logic freeChan;
    logic refuseSw;
  } arbStrobe_t;

endpackage

// File: rtl/aux_arb_ctrl.sv
module aux_arb_ctrl
  import aux_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReq,
  input  logic       swRelease,
  input  logic       mcuReq,
  input  logic       mcuRelease,
  input  logic       resetDone,
  input  logic       chanEnabled,
  input  logic       waitExpired,
  output arbStrobe_t stb
);

  arbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FREE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_FREE: begin
        if (mcuReq) begin
          stateNext    = ST_MCU;
          stb.grantMcu = 1'b1;
          stb.refuseSw = swReq;
        end else if (swReq) begin
          if (chanEnabled) begin
            stateNext   = ST_SW;
            stb.grantSw = 1'b1;
          end else begin
            stateNext    = ST_RST_HI;
            stb.startSeq = 1'b1;
          end
        end
      end
      ST_MCU: begin
        stb.refuseSw = swReq;
        if (mcuRelease) begin
          stateNext    = ST_FREE;
          stb.freeChan = 1'b1;
        end
      end
      ST_RST_HI: begin
        if (resetDone) begin
          stateNext   = ST_RST_LO;
          stb.dropRst = 1'b1;
        end else if (waitExpired) begin
          stateNext    = ST_FREE;
          stb.abortSeq = 1'b1;
        end else begin
          stb.cntRun = 1'b1;
        end
      end
      ST_RST_LO: begin
        if (!resetDone) begin
          stateNext   = ST_SW;
          stb.grantSw = 1'b1;
        end else if (waitExpired) begin
          stateNext    = ST_FREE;
          stb.abortSeq = 1'b1;
        end else begin
          stb.cntRun = 1'b1;
        end
      end
      ST_SW: begin
        if (swRelease) begin
          stateNext    = ST_FREE;
          stb.freeChan = 1'b1;
        end
      end
      default: stateNext = ST_FREE;
    endcase
  end

  AST_TIE_MCU_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FREE && mcuReq) |=> (state == ST_MCU)); // R7
  AST_DONE_ENDS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RST_HI && resetDone) |=> (state == ST_RST_LO)); // R3
  AST_SEQ_NO_MCU: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RST_LO) |-> (stateNext != ST_MCU)); // R8

endmodule

// File: rtl/aux_arb_dp.sv
module aux_arb_dp
  import aux_arb_pkg::*;
#(
  parameter int POLL_INTERVAL = 100,
  parameter int POLL_LIMIT    = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t stb,
  output logic       chanEnabled,
  output logic       waitExpired,
  output logic       auxEnable,
  output logic       auxReset,
  output logic [1:0] ownStatus,
  output logic       swRefused,
  output logic       seqError
);

  localparam int WAIT_CYCLES = POLL_INTERVAL * POLL_LIMIT;
  localparam int CNT_W       = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] waitCnt;

  assign waitExpired = (waitCnt == CNT_LAST);
  assign chanEnabled = auxEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.startSeq || stb.dropRst) begin
      waitCnt <= '0;
    end else if (stb.cntRun) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxEnable <= 1'b0;
      auxReset  <= 1'b0;
      seqError  <= 1'b0;
    end else begin
      if (stb.startSeq) begin
        auxEnable <= 1'b1;
        auxReset  <= 1'b1;
      end
      if (stb.dropRst) auxReset <= 1'b0;
      if (stb.abortSeq) begin
        auxEnable <= 1'b0;
        auxReset  <= 1'b0;
        seqError  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownStatus <= OWN_NONE;
      swRefused <= 1'b0;
    end else begin
      swRefused <= stb.refuseSw;
      if (stb.grantSw)       ownStatus <= OWN_SW;
      else if (stb.grantMcu) ownStatus <= OWN_MCU;
      else if (stb.freeChan) ownStatus <= OWN_NONE;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_LAST); // R6
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    auxReset |-> auxEnable); // R3

endmodule

// File: rtl/aux_own_arb.sv
module aux_own_arb
  import aux_arb_pkg::*;
#(
  parameter int POLL_INTERVAL = 100,
  parameter int POLL_LIMIT    = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReq,
  input  logic       swRelease,
  input  logic       mcuReq,
  input  logic       mcuRelease,
  input  logic       resetDone,
  output logic       auxEnable,
  output logic       auxReset,
  output logic [1:0] ownStatus,
  output logic       swRefused,
  output logic       seqError
);

  arbStrobe_t stb;
  logic       chanEnabled;
  logic       waitExpired;

  aux_arb_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .swReq       (swReq),
    .swRelease   (swRelease),
    .mcuReq      (mcuReq),
    .mcuRelease  (mcuRelease),
    .resetDone   (resetDone),
    .chanEnabled (chanEnabled),
    .waitExpired (waitExpired),
    .stb         (stb)
  );

  aux_arb_dp #(
    .POLL_INTERVAL (POLL_INTERVAL),
    .POLL_LIMIT    (POLL_LIMIT)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .chanEnabled (chanEnabled),
    .waitExpired (waitExpired),
    .auxEnable   (auxEnable),
    .auxReset    (auxReset),
    .ownStatus   (ownStatus),
    .swRefused   (swRefused),
    .seqError    (seqError)
  );

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ownStatus != 2'd3); // R1
  AST_MCU_REFUSES_SW: assert property (@(posedge clk) disable iff (!rstN)
    (ownStatus == OWN_MCU && swReq && !mcuRelease) |=> (ownStatus == OWN_MCU && swRefused)); // R2
  AST_NO_GRANT_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    auxReset |-> (ownStatus == OWN_NONE)); // R3
  AST_SW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (ownStatus == OWN_SW) |-> auxEnable); // R4
  AST_SW_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (ownStatus == OWN_SW && swRelease) |=> (ownStatus == OWN_NONE)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError); // R6

endmodule

// File: tb/aux_own_arb_tb.sv
`timescale 1ns/1ps
module aux_own_arb_tb_top;

  localparam int POLL_INTERVAL = 2;
  localparam int POLL_LIMIT    = 11;
  localparam int WAIT_CYCLES   = POLL_INTERVAL * POLL_LIMIT;
  localparam int NVEC          = 21;

  // {swReq, swRelease, mcuReq, mcuRelease, resetDone, expStatus[1:0], expEn, expRst, expRefused}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b0_0_1_0_0_10_0_0_0, // mcu claims free channel
    10'b1_0_0_0_0_10_0_0_1, // sw refused
    10'b0_0_0_0_0_10_0_0_0,
    10'b0_0_0_1_0_00_0_0_0, // mcu releases
    10'b1_0_0_0_0_00_1_1_0, // sw claims disabled channel
    10'b0_0_0_0_0_00_1_1_0,
    10'b0_0_1_0_0_00_1_1_0, // mcu claim during handshake ignored
    10'b0_0_0_0_1_00_1_0_0, // done seen high, reset drops
    10'b0_0_0_0_1_00_1_0_0,
    10'b0_0_0_0_0_01_1_0_0, // done low, sw granted
    10'b0_0_1_0_0_01_1_0_0, // mcu claim ignored
    10'b0_0_0_1_0_01_1_0_0, // non-owner release ignored
    10'b1_0_0_0_0_01_1_0_0, // repeated sw claim ignored
    10'b0_1_0_0_0_00_1_0_0, // sw release
    10'b0_1_0_0_0_00_1_0_0,
    10'b1_0_0_0_0_01_1_0_0, // already enabled: direct grant
    10'b0_1_0_0_0_00_1_0_0,
    10'b1_0_1_0_0_10_1_0_1, // tie: mcu wins
    10'b0_1_0_0_0_10_1_0_0, // sw release while mcu owns ignored
    10'b0_0_0_1_0_00_1_0_0,
    10'b0_0_0_1_0_00_1_0_0
  };
  localparam string TAGS [NVEC] = '{
    "R1", "R2", "R2", "R5", "R3", "R3", "R8", "R3", "R3", "R4", "R8",
    "R5", "R8", "R5", "R5", "R4", "R5", "R7", "R5", "R5", "R5"
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swReq = 1'b0, swRelease = 1'b0, mcuReq = 1'b0, mcuRelease = 1'b0, resetDone = 1'b0;
  logic auxEnable, auxReset, swRefused, seqError;
  logic [1:0] ownStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  aux_own_arb #(
    .POLL_INTERVAL (POLL_INTERVAL),
    .POLL_LIMIT    (POLL_LIMIT)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .swReq      (swReq),
    .swRelease  (swRelease),
    .mcuReq     (mcuReq),
    .mcuRelease (mcuRelease),
    .resetDone  (resetDone),
    .auxEnable  (auxEnable),
    .auxReset   (auxReset),
    .ownStatus  (ownStatus),
    .swRefused  (swRefused),
    .seqError   (seqError)
  );

  task automatic checkOut(input logic [1:0] expSt, input logic expEn, input logic expRst,
                          input logic expRef, input logic expErr, input string tag);
    nChecks++;
    if (ownStatus !== expSt || auxEnable !== expEn || auxReset !== expRst ||
        swRefused !== expRef || seqError !== expErr) begin
      nFails++;
      $display("FAIL %s: got st=%0d en=%0b rst=%0b ref=%0b err=%0b, expected st=%0d en=%0b rst=%0b ref=%0b err=%0b",
               tag, ownStatus, auxEnable, auxReset, swRefused, seqError,
               expSt, expEn, expRst, expRef, expErr);
    end
  endtask

  task automatic step(input logic [4:0] ins, input logic [1:0] expSt, input logic expEn,
                      input logic expRst, input logic expRef, input logic expErr, input string tag);
    {swReq, swRelease, mcuReq, mcuRelease, resetDone} = ins;
    @(negedge clk);
    checkOut(expSt, expEn, expRst, expRef, expErr, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {swReq, swRelease, mcuReq, mcuRelease, resetDone} = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    doReset();
    checkOut(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][9:5], VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, TAGS[i]);
    end

    // R6: reset-done never rises
    doReset();
    step(5'b10000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 start");
    for (int i = 0; i < WAIT_CYCLES - 2; i++) step(5'b00000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 wait");
    step(5'b00000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 last wait cycle");
    step(5'b00000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 expiry high wait");

    // R6: reset-done never falls
    doReset();
    step(5'b10000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 start");
    step(5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reset drop");
    for (int i = 0; i < WAIT_CYCLES - 1; i++) step(5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 low wait");
    step(5'b00001, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 expiry low wait");

    // R6 stickiness across a later successful handshake
    step(5'b10000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 retry start");
    step(5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 retry drop");
    step(5'b00000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R6 sticky after grant");
    step(5'b01000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 release");

    finishRun();
  end

endmodule